// File: doc/BRIEF.md
# Overlapping Four-Ones Serial Detector

This block watches a serial bit stream, taking one bit on each clock edge where the input strobe is high, and flags every place where the four most recent accepted bits are all 1. A match may share bits with the one before it. A run of ones therefore keeps the flag asserted on each accepted bit from the fourth onward, until a 0 arrives.

Two flags are offered. The combinational flag depends on the present state and on the bit currently offered. It is high in the same cycle as the fourth 1. The registered flag is decoded from a separate "seen four" state alone, so it rises one accepted bit later and is free of glitches caused by the input. The registered form needs one more state than the combinational form. The run length needed for a match is a parameter, `RUN_LEN`, and defaults to 4.

Top module: `ones_run_detect`

## Requirements
- R1: While `rst` is high at a clock edge, the machine returns to the empty state, in which no ones have been counted. After the edge `hit_reg` is 0, and `hit_comb` stays 0 until `RUN_LEN` ones have been accepted.
- R2: A bit is accepted only on a clock edge where `bit_vld` is 1. When `bit_vld` is 0, the state is held and `hit_comb` is 0.
- R3: `hit_comb` is 1 exactly when `bit_vld` is 1, `bit_in` is 1, and the previous `RUN_LEN-1` accepted bits were all 1.
- R4: Overlap is allowed. Every further accepted 1 after a match gives another `hit_comb` pulse.
- R5: An accepted 0 sends the machine back to the empty state.
- R6: After each clock edge, `hit_reg` is 1 exactly when the last `RUN_LEN` accepted bits were all 1. It depends on the state alone.
- R7: For the accepted input 0,1,0,1,1,1,1,1, `hit_comb` is 0,0,0,0,0,0,1,1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Strobe: the bit on `bit_in` is accepted at this edge |
| bit_in | input | 1 | Serial data bit |
| hit_comb | output | 1 | Match flag decoded from the state and the current input |
| hit_reg | output | 1 | Match flag decoded from the state only |

## Verification
The bench first applies the fixed stream from R7. This shows that `hit_comb` rises on the fourth consecutive 1 and not before it. A single 0 between ones must clear the partial count.

Next, every 10-bit pattern is swept, with the strobe held low on some cycles. This separates a correct overlap from a detector that clears after each match or that counts ones across a 0. It also catches a design that advances its state on cycles where the strobe is low.

The reference is a simple count of the run length, computed in the bench. `hit_comb` is checked in the cycle the bit is offered. `hit_reg` is checked after the edge, which tells the combinational timing apart from the registered timing.

// File: rtl/ones_run_detect.sv
module ones_run_detect #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  output logic hit_comb,
  output logic hit_reg
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(RUN_LEN);
  localparam logic [CW-1:0] NEAR = CW'(RUN_LEN - 1);

  logic [CW-1:0] st, st_nx;

  always_comb begin
    st_nx = st;
    if (bit_vld) begin
      if (!bit_in)        st_nx = '0;
      else if (st == FULL) st_nx = FULL;
      else                st_nx = st + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= st_nx;
  end

  assign hit_comb = bit_vld & bit_in & (st >= NEAR);
  assign hit_reg  = (st == FULL);

  assert_zero_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && !bit_in) |=> (!hit_reg && st == '0));

  assert_hold_no_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(st));

  assert_comb_gated_R2: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |-> !hit_comb);

  assert_reg_follows_comb_R6: assert property (@(posedge clk) disable iff (rst)
    hit_comb |=> hit_reg);

  assert_reset_empty_R1: assert property (@(posedge clk)
    rst |=> !hit_reg);

  assert_overlap_R4: assert property (@(posedge clk) disable iff (rst)
    (hit_reg && bit_vld && bit_in) |-> hit_comb);
endmodule

// File: tb/tb_ones_run_detect.sv
module tb_ones_run_detect;
  logic clk = 0, rst = 1, bit_vld = 0, bit_in = 0;
  logic hit_comb, hit_reg;
  int checks = 0, fails = 0, run = 0;
  bit done = 0;

  ones_run_detect #(.RUN_LEN(4)) dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic b, input string req);
    bit_vld = v; bit_in = b;
    #1;
    chk({req, " comb"}, hit_comb, v && b && run >= 3);
    @(posedge clk);
    if (v) run = b ? run + 1 : 0;
    #1;
    chk({req, " reg"}, hit_reg, run >= 4);
  endtask

  initial begin
    logic [7:0] r7 = 8'b01011111;
    logic [7:0] r7_exp = 8'b00000011;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset", hit_reg, 0);
    rst = 0;
    for (int i = 7; i >= 0; i--) begin
      bit_vld = 1; bit_in = r7[i];
      #1;
      chk("R7 example", hit_comb, r7_exp[i]);
      @(posedge clk);
      run = r7[i] ? run + 1 : 0;
      #1;
    end
    for (int p = 0; p < 1024; p++) begin
      for (int i = 0; i < 10; i++) begin
        if ((p + i) % 7 == 3) step(0, p[i], "R2 idle");
        step(1, p[i], "R3 R4 R5 R6 sweep");
      end
      if (p % 64 == 0) begin
        rst = 1; @(posedge clk); #1; run = 0; rst = 0;
        chk("R1 reset after sweep", hit_reg, 0);
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin #400000; fails++; checks++; $display("FAIL watchdog expired"); end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule